// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block holds the control word and the status word of a numeric coprocessor. The arithmetic datapath reports exceptions as a six-bit vector with a valid strobe. The block keeps these flags set until it is told to clear them. It compares them with the individual mask bits and a global mask bit in the control word, and from that it forms an error summary bit and an interrupt request to the host.

The block also keeps the busy bit, the four condition codes and the three-bit top-of-stack pointer. It tells the datapath how to treat a masked exception: a masked overflow gives an infinity, and a masked underflow gives a denormalised result. An exception that is neither individually nor globally masked stops the write-back of the current result at once. It then holds the coprocessor in an error-halt state, with busy held high, until the host issues a clear-exceptions command. The host reads and writes both words through a small register port. A read is combinational, and a write takes effect at the next clock edge.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the control word reads 16'h003F (all six exceptions masked, global mask clear), the status word reads 16'h0000, and irq and busy are low.
- R2: A host write with host_sel=0 loads all 16 bits of the control word; reading with host_sel=0 returns it from the next cycle on. Control bits [5:0] mask flags PE,UE,OE,ZE,DE,IE (bit 5 down to bit 0), and bit 7 is the global mask.
- R3: A flag reported with dp_exc_vld appears in status bits [5:0] (PE bit 5, UE 4, OE 3, ZE 2, DE 1, IE 0) the next cycle and stays set, ORed with later reports, until a clear command.
- R4: Status bit 7 (error summary) is high exactly when some flag is set while its control bit [5:0] is clear, whatever the global mask.
- R5: irq is high exactly when the error summary is high and control bit 7 is clear.
- R6: A clr_exc pulse clears all flags, the summary, irq and the error halt at the next edge; a flag reported in the same cycle survives the clear.
- R7: busy (also status bit 15) rises the cycle after dp_start and falls the cycle after dp_done, unless an error halt holds it.
- R8: A reported flag whose individual mask bit and global mask bit are both clear raises wb_kill in the same cycle. From the next cycle, dp_err and busy stay high (even across dp_done) until clr_exc.
- R9: hint_ovf_inf equals control bit 3 OR bit 7, and hint_unf_denorm equals control bit 4 OR bit 7, combinationally.
- R10: Status layout: C3 at bit 14, TOP at [13:11], C2..C0 at [10:8], bit 6 zero. dp_cc_we and dp_top_we load the codes and the pointer. A host write with host_sel=1 loads only C3..C0 and TOP (a datapath load in the same cycle wins); busy, summary and flags ignore the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects control word, 1 selects status word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected word, combinational |
| clr_exc | input | 1 | Clear-exceptions command |
| dp_start | input | 1 | Instruction begins executing |
| dp_done | input | 1 | Instruction finishes |
| dp_exc_vld | input | 1 | Exception vector valid |
| dp_exc | input | 6 | Exceptions raised, PE..IE in bits 5..0 |
| dp_cc_we | input | 1 | Load condition codes |
| dp_cc | input | 4 | Condition codes C3..C0 |
| dp_top_we | input | 1 | Load top-of-stack pointer |
| dp_top | input | 3 | Top-of-stack pointer |
| busy | output | 1 | Instruction executing or error halt |
| irq | output | 1 | Interrupt request to host |
| wb_kill | output | 1 | Suppress result write-back |
| dp_err | output | 1 | Error halt reported to datapath |
| hint_ovf_inf | output | 1 | Masked overflow: substitute infinity |
| hint_unf_denorm | output | 1 | Masked underflow: denormalise result |

## Verification
The hints, wb_kill and host_rdata are combinational, so the bench checks them one time step after it drives the inputs, before the next clock edge. Flags, summary, irq, dp_err and busy pass through one register. The bench checks them one time step after the first rising edge that follows the stimulus. In the vector loop each case is prepared with a control write and a clear in one cycle. The exception is raised in the next cycle, with wb_kill checked before that cycle's edge and the registered results checked after it. That keeps each vector one cycle deep, so no result is sampled early or late.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NFLAG   = 6;
  localparam int unsigned CC_W    = 4;
  localparam int unsigned TOP_W   = 3;
  localparam int unsigned GM_BIT  = 7;
  localparam logic [WORD_W-1:0] CW_RST = 16'h003F;

  typedef enum int unsigned {
    FL_IE = 0, FL_DE = 1, FL_ZE = 2, FL_OE = 3, FL_UE = 4, FL_PE = 5
  } flag_idx_e;

  // Flags whose individual mask bit is clear.
  function automatic logic [NFLAG-1:0] open_flags(input logic [NFLAG-1:0] fl,
                                                  input logic [NFLAG-1:0] msk);
    return fl & ~msk;
  endfunction

  // Assemble the status word from its fields.
  function automatic logic [WORD_W-1:0] pack_status(input logic             bsy,
                                                    input logic [CC_W-1:0]  cc,
                                                    input logic [TOP_W-1:0] top,
                                                    input logic             es,
                                                    input logic [NFLAG-1:0] fl);
    return {bsy, cc[3], top, cc[2:0], es, 1'b0, fl};
  endfunction
endpackage

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
#(
  parameter int unsigned          W   = WORD_W,
  parameter logic [WORD_W-1:0]    RST = CW_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cw_q <= RST[W-1:0];
    else if (wr_en)  cw_q <= wdata;
  end
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
  import fpx_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic [N-1:0] exc,
  input  logic [N-1:0] eff_mask,
  output logic [N-1:0] flags_q,
  output logic         raise_unmasked,
  output logic         halt_q
);
  logic [N-1:0] flag_d;
  logic [N-1:0] raise;
  logic         halt_d;

  assign raise = vld ? exc : '0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_flag
      assign flag_d[gi] = (flags_q[gi] & ~clr) | raise[gi];
    end
  endgenerate

  assign raise_unmasked = |open_flags(raise, eff_mask);
  assign halt_d         = raise_unmasked | (halt_q & ~clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      flags_q <= flag_d;
      halt_q  <= halt_d;
    end
  end
endmodule

// File: rtl/fpx_summary.sv
module fpx_summary
  import fpx_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  input  logic         gmask,
  output logic         es,
  output logic         irq,
  output logic [N-1:0] eff_mask,
  output logic         ovf_inf,
  output logic         unf_denorm
);
  assign es         = |open_flags(flags, mask);
  assign irq        = es & ~gmask;
  assign eff_mask   = mask | {N{gmask}};
  assign ovf_inf    = eff_mask[FL_OE];
  assign unf_denorm = eff_mask[FL_UE];
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        clr_exc,
  input  logic        dp_start,
  input  logic        dp_done,
  input  logic        dp_exc_vld,
  input  logic [5:0]  dp_exc,
  input  logic        dp_cc_we,
  input  logic [3:0]  dp_cc,
  input  logic        dp_top_we,
  input  logic [2:0]  dp_top,
  output logic        busy,
  output logic        irq,
  output logic        wb_kill,
  output logic        dp_err,
  output logic        hint_ovf_inf,
  output logic        hint_unf_denorm
);
  logic [WORD_W-1:0] cw_q;
  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  eff_mask;
  logic              es;
  logic              raise_unmasked;
  logic              halt_q;
  logic              exec_q;
  logic [CC_W-1:0]   cc_q;
  logic [TOP_W-1:0]  top_q;
  logic [WORD_W-1:0] sw;
  logic              cw_wr;
  logic              sw_wr;

  assign cw_wr = host_wr & ~host_sel;
  assign sw_wr = host_wr &  host_sel;

  fpx_ctrl_reg #(.W(WORD_W), .RST(CW_RST)) u_cw (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cw_wr),
    .wdata (host_wdata),
    .cw_q  (cw_q)
  );

  fpx_summary #(.N(NFLAG)) u_sum (
    .flags      (flags_q),
    .mask       (cw_q[NFLAG-1:0]),
    .gmask      (cw_q[GM_BIT]),
    .es         (es),
    .irq        (irq),
    .eff_mask   (eff_mask),
    .ovf_inf    (hint_ovf_inf),
    .unf_denorm (hint_unf_denorm)
  );

  fpx_flag_bank #(.N(NFLAG)) u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr_exc),
    .vld            (dp_exc_vld),
    .exc            (dp_exc),
    .eff_mask       (eff_mask),
    .flags_q        (flags_q),
    .raise_unmasked (raise_unmasked),
    .halt_q         (halt_q)
  );

  // Execution tracking: start wins over done in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)         exec_q <= 1'b0;
    else if (dp_start)  exec_q <= 1'b1;
    else if (dp_done)   exec_q <= 1'b0;
  end

  // Condition codes and stack pointer: datapath load wins over host.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q  <= '0;
      top_q <= '0;
    end else begin
      if (dp_cc_we)     cc_q <= dp_cc;
      else if (sw_wr)   cc_q <= {host_wdata[14], host_wdata[10:8]};
      if (dp_top_we)    top_q <= dp_top;
      else if (sw_wr)   top_q <= host_wdata[13:11];
    end
  end

  assign busy    = exec_q | halt_q;
  assign dp_err  = halt_q;
  assign wb_kill = raise_unmasked | halt_q;

  assign sw         = pack_status(busy, cc_q, top_q, es, flags_q);
  assign host_rdata = host_sel ? sw : cw_q;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_exc,
  input logic        dp_start,
  input logic        dp_exc_vld,
  input logic [15:0] cw_q,
  input logic [5:0]  flags_q,
  input logic        raise_unmasked,
  input logic        halt_q,
  input logic        busy,
  input logic        irq
);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_exc |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !cw_q[7]);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc && !dp_exc_vld) |=> (flags_q == 6'd0 && !irq && !halt_q));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> busy);

  // R8
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_unmasked |=> halt_q);

  // R8
  halt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> busy);
endmodule

bind fpx_status_unit fpx_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr_exc        (clr_exc),
  .dp_start       (dp_start),
  .dp_exc_vld     (dp_exc_vld),
  .cw_q           (cw_q),
  .flags_q        (flags_q),
  .raise_unmasked (raise_unmasked),
  .halt_q         (halt_q),
  .busy           (busy),
  .irq            (irq)
);

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NVEC       = 8;

  // vector: cw_low[7:0], exc[5:0], es, irq, kill
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h3F, 6'h3F, 1'b0, 1'b0, 1'b0},
    {8'h00, 6'h08, 1'b1, 1'b1, 1'b1},
    {8'h80, 6'h08, 1'b1, 1'b0, 1'b0},
    {8'h37, 6'h08, 1'b1, 1'b1, 1'b1},
    {8'h37, 6'h20, 1'b0, 1'b0, 1'b0},
    {8'h3E, 6'h01, 1'b1, 1'b1, 1'b1},
    {8'h3E, 6'h02, 1'b0, 1'b0, 1'b0},
    {8'hBE, 6'h01, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_sel, clr_exc, dp_start, dp_done, dp_exc_vld;
  logic        dp_cc_we, dp_top_we;
  logic [15:0] host_wdata, host_rdata;
  logic [5:0]  dp_exc;
  logic [3:0]  dp_cc;
  logic [2:0]  dp_top;
  logic        busy, irq, wb_kill, dp_err, hint_ovf_inf, hint_unf_denorm;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .clr_exc(clr_exc),
    .dp_start(dp_start), .dp_done(dp_done), .dp_exc_vld(dp_exc_vld),
    .dp_exc(dp_exc), .dp_cc_we(dp_cc_we), .dp_cc(dp_cc),
    .dp_top_we(dp_top_we), .dp_top(dp_top), .busy(busy), .irq(irq),
    .wb_kill(wb_kill), .dp_err(dp_err), .hint_ovf_inf(hint_ovf_inf),
    .hint_unf_denorm(hint_unf_denorm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    host_wr = 0; clr_exc = 0; dp_start = 0; dp_done = 0; dp_exc_vld = 0;
    dp_cc_we = 0; dp_top_we = 0; dp_exc = '0;
  endtask

  task automatic write_cw(input logic [15:0] v);
    host_wr = 1; host_sel = 0; host_wdata = v;
    tick();
    host_wr = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 0; host_sel = 0; host_wdata = '0; dp_cc = '0; dp_top = '0;
    idle();
    tick(); tick();
    rst_n = 1;
    #1;
    // R1 reset state
    host_sel = 0; #1;
    chk("R1 cw", host_rdata, 16'h003F);
    host_sel = 1; #1;
    chk("R1 sw", host_rdata, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);

    // Vector table: R4 R5 R8 R3
    for (int k = 0; k < NVEC; k++) begin
      host_wr = 1; host_sel = 0; host_wdata = {8'h00, VEC[k][16:9]}; clr_exc = 1;
      tick();
      host_wr = 0; clr_exc = 0; host_sel = 1;
      dp_exc_vld = 1; dp_exc = VEC[k][8:3];
      #1;
      chk($sformatf("R8 wb_kill vec%0d", k), wb_kill, VEC[k][0]);
      tick();
      dp_exc_vld = 0; dp_exc = '0;
      #1;
      chk($sformatf("R3 flags vec%0d", k), host_rdata[5:0], VEC[k][8:3]);
      chk($sformatf("R4 es vec%0d", k), host_rdata[7], VEC[k][2]);
      chk($sformatf("R5 irq vec%0d", k), irq, VEC[k][1]);
      chk($sformatf("R8 dp_err vec%0d", k), dp_err, VEC[k][0]);
    end

    // R2 control word readback
    host_wr = 1; host_sel = 0; host_wdata = 16'h5A3C; clr_exc = 1;
    tick();
    host_wr = 0; clr_exc = 0; #1;
    chk("R2 cw readback", host_rdata, 16'h5A3C);

    // R3 sticky accumulation, all masked
    write_cw(16'h003F);
    host_sel = 1;
    dp_exc_vld = 1; dp_exc = 6'h08; tick();
    dp_exc = 6'h02; tick();
    dp_exc_vld = 0; dp_exc = '0;
    tick(); tick();
    chk("R3 sticky or", host_rdata[5:0], 6'h0A);

    // R6 clear with simultaneous raise
    clr_exc = 1; dp_exc_vld = 1; dp_exc = 6'h01; tick();
    clr_exc = 0; dp_exc_vld = 0; dp_exc = '0; #1;
    chk("R6 raise survives clear", host_rdata[5:0], 6'h01);
    clr_exc = 1; tick(); clr_exc = 0; #1;
    chk("R6 cleared", host_rdata[5:0], 6'h00);

    // R7 busy
    dp_start = 1; tick(); dp_start = 0; #1;
    chk("R7 busy set", busy, 1);
    chk("R7 status bit15", host_rdata[15], 1);
    dp_done = 1; tick(); dp_done = 0; #1;
    chk("R7 busy clear", busy, 0);

    // R8 halt holds busy across done
    write_cw(16'h0000);
    host_sel = 1;
    dp_start = 1; tick(); dp_start = 0;
    dp_exc_vld = 1; dp_exc = 6'h04; tick();
    dp_exc_vld = 0; dp_exc = '0; #1;
    chk("R8 dp_err", dp_err, 1);
    chk("R5 irq on unmasked", irq, 1);
    dp_done = 1; tick(); dp_done = 0; tick();
    chk("R8 busy held", busy, 1);
    chk("R8 wb_kill held", wb_kill, 1);
    clr_exc = 1; tick(); clr_exc = 0; #1;
    chk("R8 busy released", busy, 0);
    chk("R6 irq cleared", irq, 0);
    chk("R6 dp_err cleared", dp_err, 0);

    // R9 hints
    write_cw(16'h0008); #1;
    chk("R9 ovf only", {hint_ovf_inf, hint_unf_denorm}, 2'b10);
    write_cw(16'h0010); #1;
    chk("R9 unf only", {hint_ovf_inf, hint_unf_denorm}, 2'b01);
    write_cw(16'h0080); #1;
    chk("R9 global", {hint_ovf_inf, hint_unf_denorm}, 2'b11);
    write_cw(16'h0000); #1;
    chk("R9 none", {hint_ovf_inf, hint_unf_denorm}, 2'b00);

    // R10 condition codes, top, host status write
    host_sel = 1;
    dp_cc_we = 1; dp_cc = 4'b1010; dp_top_we = 1; dp_top = 3'b101;
    tick();
    dp_cc_we = 0; dp_top_we = 0; #1;
    chk("R10 dp load", host_rdata, 16'h6A00);
    host_wr = 1; host_sel = 1; host_wdata = 16'hFFFF; tick();
    host_wr = 0; #1;
    chk("R10 host sw write", host_rdata, 16'h7F00);
    host_wr = 1; host_wdata = 16'h0000; dp_cc_we = 1; dp_cc = 4'b0110; tick();
    host_wr = 0; dp_cc_we = 0; #1;
    chk("R10 dp wins", host_rdata, 16'h0600);

    done = 1'b1;
    report();
  end
endmodule